// File: doc/BRIEF.md
# DDR Clock-Enable Power-State Tracker

This block follows the power state of a DDR SDRAM as seen from its controller side. On every clock edge it looks at the clock-enable level now and at the previous edge, the already-decoded command, and a flag saying whether any bank is open. From these it moves between five states: idle, active, precharge power-down, active power-down and self refresh. Any command that is not allowed in the current state produces an error pulse.

After leaving self refresh, two countdowns start. The first is a short recovery window in which only NOP or DESELECT may appear. The second is a longer lock period during which a READ is not allowed. A read-permitted output tells the surrounding logic when a READ may be issued again. The block decodes no raw pins, tracks no individual bank, and enforces no timing other than the self-refresh exit windows.

Top module: `cke_pwr_tracker`

## Requirements
- R1: After synchronous reset the state is idle (code 0), the error output is low, the previous clock-enable level is taken as low, and both exit countdowns are clear, so read-permitted is high.
- R2: With clock enable high at the previous and current edge, in idle or active, the state becomes active (code 1) if `bank_open` is high and idle (code 0) otherwise. A command outside the exit windows gives no error.
- R3: With clock enable low at both edges, precharge power-down (code 2), active power-down (code 3) and self refresh (code 4) keep their state with no error, whatever the command.
- R4: A low-to-high clock-enable edge with NOP (code 0) or DESELECT (code 1) moves precharge power-down to idle and active power-down to active, with no error.
- R5: A low-to-high clock-enable edge with NOP or DESELECT in self refresh moves to idle with no error and starts both exit countdowns.
- R6: A high-to-low clock-enable edge in idle or active with NOP or DESELECT enters precharge power-down when `bank_open` is low and active power-down when it is high.
- R7: A high-to-low clock-enable edge with AUTO REFRESH (code 6), `bank_open` low and no recovery window running enters self refresh. With a bank open it raises an error, and the state follows `bank_open`.
- R8: For RECOV_CYC edges after a self-refresh exit, any command other than NOP or DESELECT raises an error.
- R9: For LOCK_CYC edges after a self-refresh exit, a READ (code 3) raises an error. The first READ after that window gives none.
- R10: `rd_ok` is high only when the state is idle or active and both exit countdowns have expired.
- R11: Every other combination raises the error for one cycle. A low-to-high edge out of a power state with any other command still leaves that state. A high-to-low edge with any other command keeps the state following `bank_open`. Clock-enable low or rising in idle or active is legal and follows `bank_open`.
- R12: The error output is registered and reflects exactly the command at the preceding edge, high for one cycle per offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Decoded command: 0 NOP, 1 DESELECT, 2 ACTIVATE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 AUTO REFRESH, 7 MODE SET |
| bank_open | input | 1 | High when at least one bank is open |
| pwr_state | output | 3 | Current state: 0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self refresh |
| err | output | 1 | One-cycle pulse for an illegal command at the previous edge |
| rd_ok | output | 1 | READ currently permitted |

## Verification
The recovery-window check and the lock-period READ check can both be violated at the same edge. A READ issued in the first few cycles after a self-refresh exit breaks both at once. The bench provokes this and expects exactly one error pulse, with the state still following `bank_open`. An AUTO REFRESH on a falling clock enable inside the recovery window also combines self-refresh entry with the window rule: it must not enter self refresh and must flag the error. A cycle-by-cycle reference model judges both cases, along with a long random run.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_DESEL = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_AREF  = 3'd6,
        CMD_MRS   = 3'd7
    } dram_cmd_e;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_ACTIVE = 3'd1,
        PS_PPD    = 3'd2,
        PS_APD    = 3'd3,
        PS_SREF   = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CKE_LL = 2'b00,
        CKE_LH = 2'b01,
        CKE_HL = 2'b10,
        CKE_HH = 2'b11
    } cke_pair_e;

    typedef struct packed {
        pwr_state_e nxt;
        logic       bad;
        logic       sref_exit;
    } pwr_step_t;

    function automatic logic is_quiet_cmd(dram_cmd_e c);
        return (c == CMD_NOP) || (c == CMD_DESEL);
    endfunction

    function automatic logic is_run_state(pwr_state_e s);
        return (s == PS_IDLE) || (s == PS_ACTIVE);
    endfunction

    function automatic pwr_state_e follow_banks(logic open);
        return open ? PS_ACTIVE : PS_IDLE;
    endfunction

endpackage

// File: rtl/cke_edge_tracker.sv
module cke_edge_tracker
    import cke_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cke,
    output cke_pair_e pair
);
    logic cke_prev;

    always_ff @(posedge clk) begin
        if (rst) cke_prev <= 1'b0;
        else     cke_prev <= cke;
    end

    assign pair = cke_pair_e'({cke_prev, cke});

    // R1
    prev_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> (pair == CKE_HL || pair == CKE_HH));
endmodule

// File: rtl/exit_window_timer.sv
module exit_window_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (load)          count <= CNT_W'(CYCLES);
        else if (count != '0)   count <= count - 1'b1;
    end

    assign busy = (count != '0);

    // R5
    load_full_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == CNT_W'(CYCLES)));

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && busy) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/pwr_state_core.sv
module pwr_state_core
    import cke_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cke_pair_e  pair,
    input  dram_cmd_e  cmd,
    input  logic       bank_open,
    input  logic       recov_busy,
    input  logic       lock_busy,
    output pwr_state_e state,
    output logic       err,
    output logic       sref_exit
);
    pwr_step_t step;
    logic      quiet;
    logic      run;
    logic      window_bad;

    assign quiet      = is_quiet_cmd(cmd);
    assign run        = is_run_state(state);
    assign window_bad = (recov_busy && !quiet) || (lock_busy && cmd == CMD_READ);

    always_comb begin
        step.nxt       = state;
        step.bad       = 1'b0;
        step.sref_exit = 1'b0;
        unique case (pair)
            CKE_HH: begin
                if (run) begin
                    step.nxt = follow_banks(bank_open);
                    step.bad = window_bad;
                end else begin
                    step.bad = 1'b1;
                end
            end
            CKE_LL: begin
                if (run) begin
                    step.nxt = follow_banks(bank_open);
                    step.bad = window_bad;
                end
            end
            CKE_LH: begin
                if (run) begin
                    step.nxt = follow_banks(bank_open);
                    step.bad = window_bad;
                end else begin
                    step.bad = !quiet;
                    unique case (state)
                        PS_PPD:  step.nxt = PS_IDLE;
                        PS_APD:  step.nxt = PS_ACTIVE;
                        default: begin
                            step.nxt       = PS_IDLE;
                            step.sref_exit = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                if (!run) begin
                    step.bad = 1'b1;
                end else if (quiet) begin
                    step.nxt = bank_open ? PS_APD : PS_PPD;
                end else if (cmd == CMD_AREF && !bank_open && !recov_busy) begin
                    step.nxt = PS_SREF;
                end else begin
                    step.nxt = follow_banks(bank_open);
                    step.bad = 1'b1;
                end
            end
        endcase
    end

    assign sref_exit = step.sref_exit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_IDLE;
            err   <= 1'b0;
        end else begin
            state <= step.nxt;
            err   <= step.bad;
        end
    end

    // R3
    sref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_SREF && pair == CKE_LL) |=> (state == PS_SREF && !err));

    // R4
    apd_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_APD && pair == CKE_LH) |=> (state == PS_ACTIVE));

    // R8
    recov_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (recov_busy && run && pair == CKE_HH && cmd == CMD_ACT) |=> err);

    // R9
    lock_read_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_busy && run && pair == CKE_HH && cmd == CMD_READ) |=> err);

    // R7
    sref_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (run && pair == CKE_HL && cmd == CMD_AREF && !bank_open && !recov_busy)
            |=> (state == PS_SREF && !err));
endmodule

// File: rtl/cke_pwr_tracker.sv
module cke_pwr_tracker
    import cke_pwr_pkg::*;
#(
    parameter int RECOV_CYC = 10,
    parameter int LOCK_CYC  = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       bank_open,
    output logic [2:0] pwr_state,
    output logic       err,
    output logic       rd_ok
);
    cke_pair_e  pair;
    pwr_state_e state;
    logic       sref_exit;
    logic       recov_busy;
    logic       lock_busy;

    cke_edge_tracker u_edge (
        .clk  (clk),
        .rst  (rst),
        .cke  (cke),
        .pair (pair)
    );

    exit_window_timer #(.CYCLES(RECOV_CYC)) u_recov (
        .clk  (clk),
        .rst  (rst),
        .load (sref_exit),
        .busy (recov_busy)
    );

    exit_window_timer #(.CYCLES(LOCK_CYC)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .load (sref_exit),
        .busy (lock_busy)
    );

    pwr_state_core u_core (
        .clk        (clk),
        .rst        (rst),
        .pair       (pair),
        .cmd        (dram_cmd_e'(cmd)),
        .bank_open  (bank_open),
        .recov_busy (recov_busy),
        .lock_busy  (lock_busy),
        .state      (state),
        .err        (err),
        .sref_exit  (sref_exit)
    );

    assign pwr_state = state;
    assign rd_ok     = is_run_state(state) && !recov_busy && !lock_busy;

    // R10
    rd_after_exit_chk: assert property (@(posedge clk) disable iff (rst)
        sref_exit |=> !rd_ok);

    // R5
    sref_exit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sref_exit |=> (pwr_state == 3'd0));
endmodule

// File: tb/cke_pwr_tracker_tb.sv
module cke_pwr_tracker_tb;
    localparam int RECOV = 10;
    localparam int LOCK  = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       bank_open = 1'b0;
    logic [2:0] pwr_state;
    logic       err;
    logic       rd_ok;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int m_state = 0;
    bit m_err   = 1'b0;
    bit m_prev  = 1'b0;
    int m_recov = 0;
    int m_lock  = 0;

    always #2 clk = ~clk;

    cke_pwr_tracker #(.RECOV_CYC(RECOV), .LOCK_CYC(LOCK)) u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .bank_open(bank_open),
        .pwr_state(pwr_state), .err(err), .rd_ok(rd_ok)
    );

    function automatic bit m_rd_ok();
        return (m_state < 2) && (m_recov == 0) && (m_lock == 0);
    endfunction

    task automatic model(input bit c, input int cm, input bit bo);
        bit quiet = (cm == 0) || (cm == 1);
        bit in_run = (m_state < 2);
        bit viol = (m_recov > 0 && !quiet) || (m_lock > 0 && cm == 3);
        int nx = m_state;
        bit bad = 1'b0;
        bit ex = 1'b0;
        if (in_run && !(m_prev && !c)) begin
            nx = bo ? 1 : 0;
            bad = viol;
        end else if (in_run) begin
            if (quiet)                              nx = bo ? 3 : 2;
            else if (cm == 6 && !bo && m_recov == 0) nx = 4;
            else begin nx = bo ? 1 : 0; bad = 1'b1; end
        end else if (!m_prev && c) begin
            bad = !quiet;
            if (m_state == 3) nx = 1;
            else nx = 0;
            ex = (m_state == 4);
        end else if (m_prev) begin
            bad = 1'b1;
        end
        if (ex) begin
            m_recov = RECOV;
            m_lock  = LOCK;
        end else begin
            if (m_recov > 0) m_recov--;
            if (m_lock > 0)  m_lock--;
        end
        m_prev  = c;
        m_state = nx;
        m_err   = bad;
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (pwr_state !== m_state[2:0] || err !== m_err || rd_ok !== m_rd_ok()) begin
            n_fail++;
            $display("FAIL %s: actual state=%0d err=%0b rd_ok=%0b expected state=%0d err=%0b rd_ok=%0b",
                     tag, pwr_state, err, rd_ok, m_state, m_err, m_rd_ok());
        end
    endtask

    task automatic expect_val(input string tag, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic step(input bit c, input int cm, input bit bo, input string tag);
        cke = c;
        cmd = cm[2:0];
        bank_open = bo;
        @(posedge clk);
        model(c, cm, bo);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_val("R1 state", int'(pwr_state), 0);
        expect_val("R1 err", int'(err), 0);
        expect_val("R1 rd_ok", int'(rd_ok), 1);
        model(1'b0, 0, 1'b0);
        m_err = 1'b0;
        compare("R1");

        // R11 power-up: clock enable low then rising in idle is legal
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0, "R11");
        step(1'b1, 1, 1'b0, "R11");
        // R2 normal operation follows bank_open
        step(1'b1, 2, 1'b1, "R2");
        expect_val("R2 active", int'(pwr_state), 1);
        step(1'b1, 4, 1'b1, "R2");
        // R6 active power-down entry, R3 hold, R4 exit
        step(1'b0, 0, 1'b1, "R6");
        expect_val("R6 apd", int'(pwr_state), 3);
        step(1'b0, 3, 1'b1, "R3");
        step(1'b0, 7, 1'b0, "R3");
        step(1'b1, 1, 1'b1, "R4");
        expect_val("R4 active", int'(pwr_state), 1);
        // precharge power-down
        step(1'b1, 5, 1'b0, "R2");
        step(1'b0, 1, 1'b0, "R6");
        expect_val("R6 ppd", int'(pwr_state), 2);
        step(1'b0, 2, 1'b0, "R3");
        step(1'b1, 0, 1'b0, "R4");
        expect_val("R4 idle", int'(pwr_state), 0);
        // R7 auto refresh with bank open on falling edge
        step(1'b1, 0, 1'b1, "R2");
        step(1'b0, 6, 1'b1, "R7");
        expect_val("R7 err", int'(err), 1);
        step(1'b1, 0, 1'b0, "R11");
        // R7 self refresh entry
        step(1'b0, 6, 1'b0, "R7");
        expect_val("R7 sref", int'(pwr_state), 4);
        expect_val("R10 sref", int'(rd_ok), 0);
        for (int i = 0; i < 5; i++) step(1'b0, i + 2, 1'b0, "R3");
        // R5 exit
        step(1'b1, 0, 1'b0, "R5");
        expect_val("R5 idle", int'(pwr_state), 0);
        expect_val("R10 after exit", int'(rd_ok), 0);
        // R8 and R9 together: READ right after exit
        step(1'b1, 3, 1'b0, "R8");
        expect_val("R8 err", int'(err), 1);
        step(1'b1, 0, 1'b0, "R12");
        expect_val("R12 one pulse", int'(err), 0);
        step(1'b1, 2, 1'b1, "R8");
        // R8 auto refresh on falling edge inside window
        step(1'b0, 6, 1'b0, "R8");
        expect_val("R8 no sref", int'(pwr_state), 0);
        step(1'b1, 0, 1'b0, "R11");
        for (int i = 0; i < RECOV; i++) step(1'b1, 0, 1'b0, "R8");
        step(1'b1, 3, 1'b0, "R9");
        expect_val("R9 lock read", int'(err), 1);
        for (int i = 0; i < LOCK; i++) step(1'b1, 1, 1'b0, "R9");
        step(1'b1, 3, 1'b0, "R9");
        expect_val("R9 read ok", int'(err), 0);
        expect_val("R10 ready", int'(rd_ok), 1);
        // R11 illegal exit from power-down still leaves it
        step(1'b0, 0, 1'b0, "R6");
        step(1'b1, 2, 1'b0, "R11");
        expect_val("R11 err", int'(err), 1);
        expect_val("R11 left pd", int'(pwr_state), 0);
        step(1'b0, 4, 1'b0, "R11");
        expect_val("R11 hl err", int'(err), 1);
        // random run
        for (int i = 0; i < 4000; i++) begin
            bit c = ($urandom_range(0, 3) != 0) ? ~cke : cke;
            int cm = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) cm = 6;
            step(c, cm, 1'($urandom_range(0, 1)), "R12");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule